// File: doc/BRIEF.md
# Saturating ALU with Shadow Register Banks

This block is a 16-bit arithmetic/logic unit that keeps its own operand and result storage. Two X-side operand registers, two Y-side operand registers, a feedback register and a result register exist twice, once in each of two banks. A bank-select mode input decides which copy every load, operand read and result write touches. An interrupt handler can therefore switch banks and work without saving the interrupted context. A single six-bit status register is shared by both banks. It holds zero, negative, overflow, carry, sign and quotient flags.

Each cycle the block can accept one register load from the data port and one operation. The X operand comes from either X register or from an external result-bus input. The Y operand comes from either Y register or from the feedback register. The operation's value goes to the result register or to the feedback register. The stored carry flag serves as the carry-in for the carry-using add and subtract forms, so wider words are built one 16-bit slice at a time. When the saturation mode input is set, an overflowing arithmetic result headed for the result register is clamped to the most positive or most negative value. Two divide-step operations use the quotient flag to build a non-restoring division one step at a time.

Top module: `shadow_alu`

## Requirements
- R1: After reset, in both banks all registers are zero; the result output, the feedback output and every flag are zero.
- R2: When loadEn is high, loadData is written on the clock edge into the active bank's register chosen by loadSel: 0 X-reg0, 1 X-reg1, 2 Y-reg0, 3 Y-reg1, 4 feedback, 5 result. The codes 6 and 7 change no register.
- R3: xSel 0 and 1 pick X-reg0 and X-reg1, and xSel 2 or 3 picks rBusIn. ySel 0 and 1 pick Y-reg0 and Y-reg1, and ySel 2 or 3 picks the feedback register. destAf high writes the operation value to the feedback register, and low writes it to the result register.
- R4: The opcodes that add and subtract are: 2 X+Y, 3 X+Y+C, 4 X-Y, 5 X-Y-1+C. C is the stored carry flag. The new carry is the carry out of bit 15, so it is 1 for a subtraction that does not borrow.
- R5: The single-operand opcodes are: 0 pass X, 1 pass Y, 6 negate X, 7 X+1, 8 X-1, 9 absolute value of X. Negate sets carry only for X=0. Increment sets carry only for X=FFFF. Decrement sets carry unless X=0. Pass and absolute value clear carry.
- R6: Opcodes 10 AND, 11 OR, 12 XOR and 13 NOT X give the bitwise result and clear the overflow and carry flags.
- R7: The flags are flags[0] zero, flags[1] negative, flags[2] overflow, flags[3] carry, flags[4] sign and flags[5] quotient. Opcodes 0 to 13 set zero and negative from the unsaturated 16-bit value. They set overflow when the signed result does not fit in 16 bits.
- R8: Only opcode 9 writes the sign flag, with bit 15 of its X input. Every other operation leaves it unchanged.
- R9: With satEn high, an overflowing operation written to the result register stores 7FFF for a positive overflow and 8000 for a negative one. Writes to the feedback register, and all writes with satEn low, are never clamped.
- R10: Opcode 14 (first divide step) writes Y shifted left by one with a zero fill. It sets quotient = Y[15] XOR X[15] and leaves flags[4:0] unchanged.
- R11: Opcode 15 (divide step) forms T = Y+X when the quotient flag is 1, and T = Y-X otherwise. It sets quotient = T[15] XOR X[15] and writes {T[14:0], NOT quotient}. It leaves flags[4:0] unchanged, and divide results are never clamped.
- R12: Loads, operand reads and result writes touch only the bank chosen by bankSel. The other bank's registers keep their values across any activity and any bank switch. The flags are shared by both banks.
- R13: When a load and an operation write the same register in one cycle, the operation's value is stored.
- R14: In a cycle with neither opValid nor loadEn, no register and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| bankSel | input | 1 | Active register bank |
| satEn | input | 1 | Saturation mode for result-register writes |
| loadEn | input | 1 | Register load strobe |
| loadSel | input | 3 | Register chosen for the load |
| loadData | input | 16 | Load value |
| opValid | input | 1 | Operation strobe |
| opCode | input | 4 | Operation code |
| xSel | input | 2 | X operand source |
| ySel | input | 2 | Y operand source |
| destAf | input | 1 | Destination: 1 feedback, 0 result register |
| rBusIn | input | 16 | External result-bus operand for X |
| resultOut | output | 16 | Active bank's result register |
| feedbackOut | output | 16 | Active bank's feedback register |
| flags | output | 6 | Status flags {quotient, sign, carry, overflow, negative, zero} |

## Verification
The sweep drives every non-divide opcode with operands 0, 1, 7FFE, 7FFF, 8000, 8001, FFFF and 1234. This covers the overflow edges where an inverted overflow test, or a clamp in the wrong direction, would store 8000 in place of 7FFF. It also shows a carry sense flipped for subtraction and a negate or decrement whose carry is wrong at zero. Each op is checked against a separate integer model. Directed cases cover the following:
- A two-slice add, which fails if the stored carry is not fed back.
- A same-cycle load and operation collision.
- Loads with the unused select codes.
- Bank switches, where a register written through the wrong bank or a banked flag register would show.
- Divide-step sequences that fail if the quotient flag picks add and subtract the wrong way round.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;

  typedef enum logic [3:0] {
    OP_PASSX = 4'h0, OP_PASSY = 4'h1, OP_ADD  = 4'h2, OP_ADDC = 4'h3,
    OP_SUB   = 4'h4, OP_SUBB  = 4'h5, OP_NEG  = 4'h6, OP_INC  = 4'h7,
    OP_DEC   = 4'h8, OP_ABS   = 4'h9, OP_AND  = 4'hA, OP_OR   = 4'hB,
    OP_XOR   = 4'hC, OP_NOT   = 4'hD, OP_DIVS = 4'hE, OP_DIVQ = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {A_X, A_Y, A_ZERO} a_src_e;
  typedef enum logic [2:0] {B_Y, B_NY, B_ZERO, B_ONES, B_NX, B_X} b_src_e;
  typedef enum logic [1:0] {C_ZERO, C_ONE, C_CARRY} c_src_e;
  typedef enum logic [2:0] {R_SUM, R_AND, R_OR, R_XOR, R_NOT, R_DIVS, R_DIVQ} r_src_e;

  typedef struct packed {
    a_src_e aSrc;
    b_src_e bSrc;
    c_src_e cSrc;
    r_src_e rSrc;
    logic   wrAr;
    logic   wrAf;
    logic   satOk;
    logic   updArith;
    logic   updSign;
    logic   updQuot;
  } alu_strobe_t;

  localparam int NUM_REGS = 6;
  localparam int RG_AX0 = 0;
  localparam int RG_AY0 = 2;
  localparam int RG_AF  = 4;
  localparam int RG_AR  = 5;

  localparam int FLAG_W = 6;
  localparam int F_AZ = 0;
  localparam int F_AN = 1;
  localparam int F_AV = 2;
  localparam int F_AC = 3;
  localparam int F_AS = 4;
  localparam int F_AQ = 5;

endpackage

// File: rtl/alu_ctrl.sv
`timescale 1ns/1ps
module alu_ctrl
  import alu_pkg::*;
(
  input  logic        opValid,
  input  logic [3:0]  opCode,
  input  logic        destAf,
  input  logic        xSign,
  input  logic        quotFlag,
  output alu_strobe_t strb
);
  alu_op_e op;
  assign op = alu_op_e'(opCode);

  always_comb begin
    strb          = '0;
    strb.aSrc     = A_X;
    strb.bSrc     = B_ZERO;
    strb.cSrc     = C_ZERO;
    strb.rSrc     = R_SUM;
    strb.wrAr     = opValid && !destAf;
    strb.wrAf     = opValid && destAf;
    strb.satOk    = 1'b1;
    strb.updArith = opValid;
    case (op)
      OP_PASSX: ;
      OP_PASSY: strb.aSrc = A_Y;
      OP_ADD:   strb.bSrc = B_Y;
      OP_ADDC:  begin strb.bSrc = B_Y;  strb.cSrc = C_CARRY; end
      OP_SUB:   begin strb.bSrc = B_NY; strb.cSrc = C_ONE;   end
      OP_SUBB:  begin strb.bSrc = B_NY; strb.cSrc = C_CARRY; end
      OP_NEG:   begin strb.aSrc = A_ZERO; strb.bSrc = B_NX; strb.cSrc = C_ONE; end
      OP_INC:   strb.cSrc = C_ONE;
      OP_DEC:   strb.bSrc = B_ONES;
      OP_ABS: begin
        strb.updSign = opValid;
        if (xSign) begin
          strb.aSrc = A_ZERO; strb.bSrc = B_NX; strb.cSrc = C_ONE;
        end
      end
      OP_AND:   strb.rSrc = R_AND;
      OP_OR:    strb.rSrc = R_OR;
      OP_XOR:   strb.rSrc = R_XOR;
      OP_NOT:   strb.rSrc = R_NOT;
      OP_DIVS: begin
        strb.rSrc = R_DIVS; strb.satOk = 1'b0;
        strb.updArith = 1'b0; strb.updQuot = opValid;
      end
      OP_DIVQ: begin
        strb.aSrc = A_Y;
        strb.bSrc = quotFlag ? B_X : B_NX;
        strb.cSrc = quotFlag ? C_ZERO : C_ONE;
        strb.rSrc = R_DIVQ; strb.satOk = 1'b0;
        strb.updArith = 1'b0; strb.updQuot = opValid;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
`timescale 1ns/1ps
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  alu_strobe_t       strb,
  input  logic              satEn,
  input  logic              bankSel,
  input  logic              loadEn,
  input  logic [2:0]        loadSel,
  input  logic [WIDTH-1:0]  loadData,
  input  logic [1:0]        xSel,
  input  logic [1:0]        ySel,
  input  logic [WIDTH-1:0]  rBusIn,
  output logic              xSign,
  output logic              quotFlag,
  output logic [WIDTH-1:0]  resultOut,
  output logic [WIDTH-1:0]  feedbackOut,
  output logic [FLAG_W-1:0] flags
);
  localparam int BANKS = 2;
  localparam int MSB = WIDTH - 1;
  localparam logic [WIDTH-1:0] MAX_POS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MAX_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0]  regFlat   [BANKS*NUM_REGS];
  logic [WIDTH-1:0]  activeReg [NUM_REGS];
  logic [WIDTH-1:0]  xOp, yOp, addA, addB, aluRes, arNext;
  logic [WIDTH:0]    sumFull;
  logic              cin, ovf, vBit, cBit, newQuot;
  logic [FLAG_W-1:0] flagQ;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_act
    assign activeReg[i] = bankSel ? regFlat[NUM_REGS + i] : regFlat[i];
  end

  assign xOp = xSel[1] ? rBusIn : activeReg[RG_AX0 + int'(xSel[0])];
  assign yOp = ySel[1] ? activeReg[RG_AF] : activeReg[RG_AY0 + int'(ySel[0])];
  assign xSign    = xOp[MSB];
  assign quotFlag = flagQ[F_AQ];

  always_comb begin
    case (strb.aSrc)
      A_X:     addA = xOp;
      A_Y:     addA = yOp;
      default: addA = '0;
    endcase
    case (strb.bSrc)
      B_Y:     addB = yOp;
      B_NY:    addB = ~yOp;
      B_ONES:  addB = '1;
      B_NX:    addB = ~xOp;
      B_X:     addB = xOp;
      default: addB = '0;
    endcase
    case (strb.cSrc)
      C_ONE:   cin = 1'b1;
      C_CARRY: cin = flagQ[F_AC];
      default: cin = 1'b0;
    endcase
  end

  assign sumFull = {1'b0, addA} + {1'b0, addB} + {{WIDTH{1'b0}}, cin};
  assign ovf     = (addA[MSB] == addB[MSB]) && (sumFull[MSB] != addA[MSB]);
  assign newQuot = (strb.rSrc == R_DIVS) ? (yOp[MSB] ^ xOp[MSB])
                                         : (sumFull[MSB] ^ xOp[MSB]);

  always_comb begin
    case (strb.rSrc)
      R_AND:   aluRes = xOp & yOp;
      R_OR:    aluRes = xOp | yOp;
      R_XOR:   aluRes = xOp ^ yOp;
      R_NOT:   aluRes = ~xOp;
      R_DIVS:  aluRes = {yOp[MSB-1:0], 1'b0};
      R_DIVQ:  aluRes = {sumFull[MSB-1:0], ~newQuot};
      default: aluRes = sumFull[MSB:0];
    endcase
  end

  assign vBit   = (strb.rSrc == R_SUM) && ovf;
  assign cBit   = (strb.rSrc == R_SUM) && sumFull[WIDTH];
  assign arNext = (strb.satOk && satEn && vBit) ? (aluRes[MSB] ? MAX_POS : MAX_NEG) : aluRes;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      localparam bit IS_AR = (r == RG_AR);
      localparam bit IS_AF = (r == RG_AF);
      logic [WIDTH-1:0] q;
      logic ldHit, opHit;
      assign ldHit = loadEn && (bankSel == 1'(b)) && (loadSel == 3'(r));
      assign opHit = (bankSel == 1'(b)) && ((IS_AR && strb.wrAr) || (IS_AF && strb.wrAf));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)      q <= '0;
        else if (opHit) q <= IS_AR ? arNext : aluRes;
        else if (ldHit) q <= loadData;
      end
      assign regFlat[b*NUM_REGS + r] = q;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else begin
      if (strb.updArith) begin
        flagQ[F_AZ] <= (aluRes == '0);
        flagQ[F_AN] <= aluRes[MSB];
        flagQ[F_AV] <= vBit;
        flagQ[F_AC] <= cBit;
      end
      if (strb.updSign) flagQ[F_AS] <= xOp[MSB];
      if (strb.updQuot) flagQ[F_AQ] <= newQuot;
    end
  end

  assign resultOut   = activeReg[RG_AR];
  assign feedbackOut = activeReg[RG_AF];
  assign flags       = flagQ;
endmodule

// File: rtl/shadow_alu.sv
`timescale 1ns/1ps
module shadow_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bankSel,
  input  logic              satEn,
  input  logic              loadEn,
  input  logic [2:0]        loadSel,
  input  logic [WIDTH-1:0]  loadData,
  input  logic              opValid,
  input  logic [3:0]        opCode,
  input  logic [1:0]        xSel,
  input  logic [1:0]        ySel,
  input  logic              destAf,
  input  logic [WIDTH-1:0]  rBusIn,
  output logic [WIDTH-1:0]  resultOut,
  output logic [WIDTH-1:0]  feedbackOut,
  output logic [FLAG_W-1:0] flags
);
  alu_strobe_t strb;
  logic xSign, quotFlag;

  alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .destAf  (destAf),
    .xSign   (xSign),
    .quotFlag(quotFlag),
    .strb    (strb)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .satEn      (satEn),
    .bankSel    (bankSel),
    .loadEn     (loadEn),
    .loadSel    (loadSel),
    .loadData   (loadData),
    .xSel       (xSel),
    .ySel       (ySel),
    .rBusIn     (rBusIn),
    .xSign      (xSign),
    .quotFlag   (quotFlag),
    .resultOut  (resultOut),
    .feedbackOut(feedbackOut),
    .flags      (flags)
  );
endmodule

// File: rtl/shadow_alu_chk.sv
`timescale 1ns/1ps
module shadow_alu_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = 16
)(
  input logic              clk,
  input logic              rstN,
  input logic              bankSel,
  input logic              satEn,
  input logic              loadEn,
  input logic              opValid,
  input logic [3:0]        opCode,
  input logic              destAf,
  input logic [WIDTH-1:0]  resultOut,
  input logic [FLAG_W-1:0] flags
);
  localparam logic [WIDTH-1:0] TOP_POS = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] TOP_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic isLogicOp, isDivOp, isArithOp;
  assign isLogicOp = opCode inside {OP_AND, OP_OR, OP_XOR, OP_NOT};
  assign isDivOp   = opCode inside {OP_DIVS, OP_DIVQ};
  assign isArithOp = !isLogicOp && !isDivOp;

  // R6
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isLogicOp) |=> (!flags[F_AV] && !flags[F_AC]));

  // R9
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isArithOp && !destAf && satEn && !loadEn) |=>
      (!flags[F_AV] || (bankSel != $past(bankSel)) ||
       (resultOut == TOP_POS) || (resultOut == TOP_NEG)));

  // R10 R11
  div_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isDivOp) |=> (flags[F_AS:F_AZ] == $past(flags[F_AS:F_AZ])));

  // R8
  sign_abs_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!(opValid && opCode == OP_ABS)) |=> $stable(flags[F_AS]));

  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!opValid && !loadEn) |=> $stable(flags));

  // R7
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isArithOp && !destAf && !satEn) |=>
      ((bankSel != $past(bankSel)) || (flags[F_AZ] == (resultOut == '0))));
endmodule

bind shadow_alu shadow_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .bankSel(bankSel), .satEn(satEn), .loadEn(loadEn),
  .opValid(opValid), .opCode(opCode), .destAf(destAf),
  .resultOut(resultOut), .flags(flags)
);

// File: tb/shadow_alu_test.sv
`timescale 1ns/1ps
module shadow_alu_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, bankSel, satEn, loadEn, opValid, destAf;
  logic [2:0]  loadSel;
  logic [15:0] loadData, rBusIn;
  logic [3:0]  opCode;
  logic [1:0]  xSel, ySel;
  logic [15:0] resultOut, feedbackOut;
  logic [5:0]  flags;

  shadow_alu uut (
    .clk(clk), .rstN(rstN), .bankSel(bankSel), .satEn(satEn), .loadEn(loadEn),
    .loadSel(loadSel), .loadData(loadData), .opValid(opValid), .opCode(opCode),
    .xSel(xSel), .ySel(ySel), .destAf(destAf), .rBusIn(rBusIn),
    .resultOut(resultOut), .feedbackOut(feedbackOut), .flags(flags)
  );

  int total = 0;
  int bad = 0;

  int mAx[2][2];
  int mAy[2][2];
  int mAf[2];
  int mAr[2];
  logic [5:0] mFl;
  bit lastSat;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string req, input string flagReq);
    chk(req, "result", int'(resultOut), mAr[bankSel]);
    chk(req, "feedback", int'(feedbackOut), mAf[bankSel]);
    chk(flagReq, "flags", int'(flags), int'(mFl));
  endtask

  function automatic string opReq(input int op);
    if (op >= 2 && op <= 5) return "R4";
    if (op <= 9)            return "R5";
    if (op <= 13)           return "R6";
    if (op == 14)           return "R10";
    return "R11";
  endfunction

  function automatic int toSigned(input int v);
    return (v > 32767) ? v - 65536 : v;
  endfunction

  task automatic modelLoad(input int sel, input int data);
    int b = int'(bankSel);
    case (sel)
      0: mAx[b][0] = data;
      1: mAx[b][1] = data;
      2: mAy[b][0] = data;
      3: mAy[b][1] = data;
      4: mAf[b] = data;
      5: mAr[b] = data;
      default: ;
    endcase
  endtask

  task automatic modelOp(input int op, input int xs, input int ys, input bit dst,
                         input bit sat, input int rbus);
    int b = int'(bankSel);
    int xv, yv, sx, sy, t, res, d, tt;
    bit c, v, nq;
    xv = (xs >= 2) ? rbus : mAx[b][xs & 1];
    yv = (ys >= 2) ? mAf[b] : mAy[b][ys & 1];
    sx = toSigned(xv);
    sy = toSigned(yv);
    c = 1'b0; t = 0; res = 0;
    case (op)
      0: begin res = xv; t = sx; end
      1: begin res = yv; t = sy; end
      2: begin d = xv + yv; res = d & 65535; c = (d > 65535); t = sx + sy; end
      3: begin d = xv + yv + int'(mFl[3]); res = d & 65535; c = (d > 65535);
               t = sx + sy + int'(mFl[3]); end
      4: begin d = xv - yv; res = d & 65535; c = (d >= 0); t = sx - sy; end
      5: begin d = xv - yv - 1 + int'(mFl[3]); res = d & 65535; c = (d >= 0);
               t = sx - sy - 1 + int'(mFl[3]); end
      6: begin res = (65536 - xv) & 65535; c = (xv == 0); t = -sx; end
      7: begin res = (xv + 1) & 65535; c = (xv == 65535); t = sx + 1; end
      8: begin res = (xv + 65535) & 65535; c = (xv != 0); t = sx - 1; end
      9: begin t = (sx < 0) ? -sx : sx; res = t & 65535; end
      10: res = xv & yv;
      11: res = xv | yv;
      12: res = xv ^ yv;
      13: res = (~xv) & 65535;
      14: begin res = (yv << 1) & 65535; mFl[5] = ((yv >> 15) ^ (xv >> 15)) != 0; end
      default: begin
        tt = mFl[5] ? (yv + xv) : (yv - xv);
        tt = tt & 65535;
        nq = ((tt >> 15) ^ (xv >> 15)) != 0;
        res = ((tt << 1) | (nq ? 0 : 1)) & 65535;
        mFl[5] = nq;
      end
    endcase
    v = (op <= 9) && (t > 32767 || t < -32768);
    lastSat = 1'b0;
    if (op <= 13) begin
      mFl[0] = (res == 0);
      mFl[1] = ((res >> 15) & 1) != 0;
      mFl[2] = v;
      mFl[3] = c;
      if (op == 9) mFl[4] = ((xv >> 15) & 1) != 0;
    end
    if (dst) mAf[b] = res;
    else if (sat && v) begin
      mAr[b] = (t > 0) ? 32767 : 32768;
      lastSat = 1'b1;
    end
    else mAr[b] = res;
  endtask

  task automatic ld(input int sel, input int data);
    @(negedge clk);
    loadEn = 1'b1; loadSel = 3'(sel); loadData = 16'(data);
    modelLoad(sel, data);
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic op(input int opc, input int xs, input int ys, input bit dst,
                    input bit sat, input int rbus, input bit withLd, input int lSel,
                    input int lData);
    @(negedge clk);
    opValid = 1'b1; opCode = 4'(opc); xSel = 2'(xs); ySel = 2'(ys);
    destAf = dst; satEn = sat; rBusIn = 16'(rbus);
    if (withLd) begin
      loadEn = 1'b1; loadSel = 3'(lSel); loadData = 16'(lData);
      modelLoad(lSel, lData);
    end
    modelOp(opc, xs, ys, dst, sat, rbus);
    @(negedge clk);
    opValid = 1'b0; loadEn = 1'b0;
  endtask

  task automatic runOp(input int opc, input int xs, input int ys, input bit dst,
                       input bit sat, input int rbus);
    op(opc, xs, ys, dst, sat, rbus, 1'b0, 0, 0);
    checkAll(lastSat ? "R9" : opReq(opc), (opc == 9) ? "R8" : "R7");
  endtask

  initial begin
    #(8 * 190000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int vals[8];
    int lowSum, highSum;
    vals = '{0, 1, 16'h7FFE, 16'h7FFF, 16'h8000, 16'h8001, 16'hFFFF, 16'h1234};
    for (int b = 0; b < 2; b++) begin
      mAf[b] = 0; mAr[b] = 0;
      for (int k = 0; k < 2; k++) begin mAx[b][k] = 0; mAy[b][k] = 0; end
    end
    mFl = '0; lastSat = 1'b0;
    rstN = 1'b0; bankSel = 1'b0; satEn = 1'b0; loadEn = 1'b0; opValid = 1'b0;
    destAf = 1'b0; loadSel = '0; loadData = '0; rBusIn = '0; opCode = '0;
    xSel = '0; ySel = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state in both banks
    checkAll("R1", "R1");
    bankSel = 1'b1;
    @(negedge clk);
    checkAll("R1", "R1");
    bankSel = 1'b0;

    // R4 R5 R6 R7 R9 sweep over corner operands
    for (int opc = 0; opc < 14; opc++) begin
      for (int xi = 0; xi < 8; xi++) begin
        for (int yi = 0; yi < 8; yi++) begin
          ld(0, vals[xi]);
          ld(2, vals[yi]);
          runOp(opc, 0, 0, 1'((xi + yi) & 1), 1'(((xi >> 1) ^ yi) & 1), 0);
        end
      end
    end

    // R4 two-slice add through the stored carry: 0001FFFF + 00010001
    ld(0, 16'hFFFF); ld(2, 16'h0001);
    runOp(2, 0, 0, 1'b1, 1'b0, 0);
    lowSum = int'(feedbackOut);
    ld(1, 16'h0001); ld(3, 16'h0001);
    runOp(3, 1, 1, 1'b0, 1'b0, 0);
    highSum = int'(resultOut);
    chk("R4", "wide sum", (highSum << 16) | lowSum, 32'h00030000);

    // R3 operand sources
    ld(0, 16'h1111); ld(1, 16'h2222); ld(2, 16'h3333); ld(3, 16'h4444);
    runOp(0, 1, 0, 1'b0, 1'b0, 0);
    chk("R3", "x-reg1", int'(resultOut), 16'h2222);
    runOp(0, 2, 0, 1'b1, 1'b0, 16'h5A5A);
    chk("R3", "rbus", int'(feedbackOut), 16'h5A5A);
    runOp(1, 0, 1, 1'b0, 1'b0, 0);
    chk("R3", "y-reg1", int'(resultOut), 16'h4444);
    runOp(2, 0, 2, 1'b0, 1'b0, 0);
    chk("R3", "y from feedback", int'(resultOut), 16'h6B6B);

    // R2 unused select codes change nothing
    ld(6, 16'hDEAD); ld(7, 16'hBEEF);
    checkAll("R2", "R2");
    runOp(0, 0, 0, 1'b1, 1'b0, 0);
    chk("R2", "x-reg0 after unused load", int'(feedbackOut), 16'h1111);
    runOp(1, 0, 0, 1'b1, 1'b0, 0);
    chk("R2", "y-reg0 after unused load", int'(feedbackOut), 16'h3333);
    ld(5, 16'h0F0F);
    checkAll("R2", "R2");

    // R13 load and op to the same register in one cycle
    op(2, 0, 0, 1'b0, 1'b0, 0, 1'b1, 5, 16'hCAFE);
    checkAll("R13", "R7");
    chk("R13", "op wins", int'(resultOut), 16'h4444);

    // R12 bank isolation, shared flags
    @(negedge clk); bankSel = 1'b1;
    @(negedge clk);
    checkAll("R12", "R12");
    ld(0, 16'h7FFF); ld(2, 16'h0001);
    runOp(2, 0, 0, 1'b0, 1'b1, 0);
    chk("R12", "bank1 saturated", int'(resultOut), 16'h7FFF);
    @(negedge clk); bankSel = 1'b0;
    @(negedge clk);
    checkAll("R12", "R12");
    runOp(0, 0, 0, 1'b1, 1'b0, 0);
    chk("R12", "bank0 x-reg0 kept", int'(feedbackOut), 16'h1111);
    @(negedge clk); bankSel = 1'b1;
    @(negedge clk);
    chk("R12", "bank1 feedback kept", int'(feedbackOut), mAf[1]);
    bankSel = 1'b0;

    // R14 idle cycles with moving inputs
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      rBusIn = 16'(k * 16'h1357); opCode = 4'(k); satEn = 1'(k);
      checkAll("R14", "R14");
    end

    // R10 R11 divide step sequences
    for (int p = 0; p < 6; p++) begin
      ld(0, (p * 16'h2345 + 16'h0103) & 16'hFFFF);
      ld(4, (p * 16'h6F01 + 16'h0050) & 16'hFFFF);
      runOp(14, 0, 2, 1'b1, 1'b1, 0);
      for (int s = 0; s < 5; s++) runOp(15, 0, 2, 1'b1, 1'b1, 0);
      runOp(15, 0, 2, 1'b0, 1'b1, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule